// File: doc/BRIEF.md
# Programmable Dual-Mode Peripheral Select Generator

This block turns an I/O bus address and its read and write strobes into three peripheral select lines. In general-purpose mode each line is an active-low select for one programmable address window. In encoded mode the three lines carry a single 3-bit device code, which an external 3-to-8 decoder expands into individual selects. That code covers two serial ports, a parallel port, a disk interface range and the three programmable windows.

Each window has a 16-bit base and an 8-bit low-order mask. Both are written through a small byte-wide configuration port. A bit in a separate mode register chooses between the two output functions.

Line 0 also serves as a strap. While reset is active the block releases line 0 (its output enable is low), so the pad level can be read. The level present in the last reset cycle is held and exported. A 1 selects the test function of the test pin and a 0 selects its init function.

Top module: `csel_gen`

## Requirements
- R1: Configuration writes (`cfg_we` high at a clock edge) update these registers. Window n (n = 0..2) has its base low byte at offset 64h+4n, its base high byte at 65h+4n and its mask at 66h+4n. The mode register is at 4Ch, and its bit 4 selects encoded mode when 1. All registers clear to zero on reset.
- R2: Window n hits when (addr AND NOT mask16) equals (base AND NOT mask16), where mask16 is the 8-bit mask zero-extended to 16 bits.
- R3: After reset a window never hits until at least one of its three registers has been written, even though base and mask are zero.
- R4: In general-purpose mode, `cs_out[n]` is 0 exactly when `io_rd` or `io_wr` is high and window n hits. Two or more lines may be low together.
- R5: In encoded mode with a strobe active, `cs_out` gives one code. The codes are 000 for 3F8h–3FFh, 001 for 2F8h–2FFh, 010 for 378h–37Fh, 011 for 1F0h–1F7h, 100/101/110 for hits on windows 0/1/2, and 111 when nothing hits.
- R6: In encoded mode, when several ranges or windows match, the lowest code is output.
- R7: With neither `io_rd` nor `io_wr` high, `cs_out` is 111 in both modes.
- R8: While `rst` is high `cs_oe` is 110, so line 0 is released. Outside reset `cs_oe` is 111.
- R9: `strap_test` equals the level of `cs0_pad_in` at the last clock edge with `rst` high. It then holds until the next reset, whatever the pad does.
- R10: The selects and codes are combinational from the address and strobes. They react within the same cycle, and a register write affects them from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O bus address |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cs0_pad_in | input | 1 | Pad level of select line 0, read as the strap |
| cs_out | output | 3 | Active-low selects or 3-bit device code |
| cs_oe | output | 3 | Per-line output enable; bit 0 is low during reset |
| strap_test | output | 1 | Latched strap: 1 for test function, 0 for init function |

## Verification
The bench programs a window with a zero base and an all-ones mask. A design that forgot the per-window enable, or that read the mask the wrong way round, would then decode address 0 or miss the window. Overlapping programmable windows, and a window laid over a fixed serial range, expose encoders that pick the highest match instead of the lowest. In general-purpose mode, overlapping windows must drive several lines low together, and one-hot logic would show only one.

The strap is checked with both levels, with the pad flipped right after reset. A latch that kept sampling would follow the pad. Random register writes mixed with random and near-window addresses catch offset and byte-lane mistakes. A final reset shows whether the registers really clear.

// File: rtl/csel_gen_pkg.sv
package csel_gen_pkg;

    localparam int NUM_WIN   = 3;
    localparam int ADDR_W    = 16;
    localparam int MASK_W    = 8;
    localparam int CODE_W    = 3;
    localparam int REG_AW    = 8;
    localparam int REG_DW    = 8;
    localparam int OCTET_LSB = 3;

    localparam logic [REG_AW-1:0] MODE_REG_OFS = 8'h4C;
    localparam int                MODE_ENC_BIT = 4;
    localparam logic [REG_AW-1:0] WIN_REG_BASE = 8'h64;
    localparam int                WIN_STRIDE   = 4;

    localparam logic [ADDR_W-1:0] SER_A_BASE = 16'h03F8;
    localparam logic [ADDR_W-1:0] SER_B_BASE = 16'h02F8;
    localparam logic [ADDR_W-1:0] PAR_BASE   = 16'h0378;
    localparam logic [ADDR_W-1:0] DISK_BASE  = 16'h01F0;

    typedef enum logic [CODE_W-1:0] {
        CODE_SER_A = 3'd0,
        CODE_SER_B = 3'd1,
        CODE_PAR   = 3'd2,
        CODE_DISK  = 3'd3,
        CODE_WIN0  = 3'd4,
        CODE_IDLE  = 3'd7
    } dev_code_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [MASK_W-1:0] mask;
        logic              en;
    } win_cfg_t;

    function automatic logic in_octet(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] b);
        return a[ADDR_W-1:OCTET_LSB] == b[ADDR_W-1:OCTET_LSB];
    endfunction

    function automatic logic win_match(input logic [ADDR_W-1:0] a,
                                       input win_cfg_t c);
        logic [ADDR_W-1:0] keep;
        keep = ~{{(ADDR_W-MASK_W){1'b0}}, c.mask};
        return c.en && ((a & keep) == (c.base & keep));
    endfunction

endpackage

// File: rtl/csel_cfg_regs.sv
module csel_cfg_regs
    import csel_gen_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [REG_AW-1:0]             addr,
    input  logic [REG_DW-1:0]             wdata,
    output win_cfg_t [NUM_WIN-1:0]        win,
    output logic                          enc_mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_mode <= 1'b0;
        end else if (we && addr == MODE_REG_OFS) begin
            enc_mode <= wdata[MODE_ENC_BIT];
        end
    end

    for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
        localparam logic [REG_AW-1:0] OFS_LO   = REG_AW'(WIN_REG_BASE + WIN_STRIDE*n);
        localparam logic [REG_AW-1:0] OFS_HI   = REG_AW'(WIN_REG_BASE + WIN_STRIDE*n + 1);
        localparam logic [REG_AW-1:0] OFS_MASK = REG_AW'(WIN_REG_BASE + WIN_STRIDE*n + 2);

        always_ff @(posedge clk) begin
            if (rst) begin
                win[n] <= '0;
            end else if (we) begin
                if (addr == OFS_LO) begin
                    win[n].base[7:0] <= wdata;
                    win[n].en        <= 1'b1;
                end
                if (addr == OFS_HI) begin
                    win[n].base[15:8] <= wdata;
                    win[n].en         <= 1'b1;
                end
                if (addr == OFS_MASK) begin
                    win[n].mask <= wdata;
                    win[n].en   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/csel_window.sv
module csel_window
    import csel_gen_pkg::*;
(
    input  logic [ADDR_W-1:0] io_addr,
    input  win_cfg_t          cfg,
    output logic              hit
);

    assign hit = win_match(io_addr, cfg);

endmodule

// File: rtl/csel_encoder.sv
module csel_encoder
    import csel_gen_pkg::*;
(
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               strobe,
    input  logic               enc_mode,
    input  logic [NUM_WIN-1:0] hit,
    output logic [CODE_W-1:0]  cs_out
);

    logic [CODE_W-1:0] code;
    logic              found;

    always_comb begin
        code  = CODE_IDLE;
        found = 1'b0;
        if (in_octet(io_addr, SER_A_BASE)) begin
            code = CODE_SER_A; found = 1'b1;
        end else if (in_octet(io_addr, SER_B_BASE)) begin
            code = CODE_SER_B; found = 1'b1;
        end else if (in_octet(io_addr, PAR_BASE)) begin
            code = CODE_PAR;   found = 1'b1;
        end else if (in_octet(io_addr, DISK_BASE)) begin
            code = CODE_DISK;  found = 1'b1;
        end
        for (int i = 0; i < NUM_WIN; i++) begin
            if (!found && hit[i]) begin
                code  = CODE_W'(CODE_WIN0 + i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        if (!strobe) begin
            cs_out = '1;
        end else if (enc_mode) begin
            cs_out = code;
        end else begin
            cs_out = ~hit;
        end
    end

endmodule

// File: rtl/csel_gen.sv
module csel_gen
    import csel_gen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    input  logic        cs0_pad_in,
    output logic [2:0]  cs_out,
    output logic [2:0]  cs_oe,
    output logic        strap_test
);

    win_cfg_t [NUM_WIN-1:0] win;
    logic                   enc_mode;
    logic [NUM_WIN-1:0]     hit;
    logic                   strap_q;

    csel_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .win      (win),
        .enc_mode (enc_mode)
    );

    for (genvar n = 0; n < NUM_WIN; n++) begin : g_dec
        csel_window u_win (
            .io_addr (io_addr),
            .cfg     (win[n]),
            .hit     (hit[n])
        );
    end

    csel_encoder u_enc (
        .io_addr  (io_addr),
        .strobe   (io_rd | io_wr),
        .enc_mode (enc_mode),
        .hit      (hit),
        .cs_out   (cs_out)
    );

    // Strap capture: follows the pad every reset cycle, frozen afterwards.
    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= cs0_pad_in;
        end
    end

    assign strap_test = strap_q;
    assign cs_oe      = {{(NUM_WIN-1){1'b1}}, ~rst};

endmodule

// File: rtl/csel_gen_chk.sv
module csel_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] io_addr,
    input logic        io_rd,
    input logic        io_wr,
    input logic        enc_mode,
    input logic [2:0]  cs_out,
    input logic [2:0]  cs_oe,
    input logic        strap_test
);

    a_r7_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !(io_rd || io_wr) |-> cs_out == 3'b111);

    a_r5_serial_a_code: assert property (@(posedge clk) disable iff (rst)
        (enc_mode && (io_rd || io_wr) && io_addr[15:3] == 13'h007F) |-> cs_out == 3'b000);

    a_r8_all_driven: assert property (@(posedge clk) disable iff (rst)
        cs_oe == 3'b111);

    a_r9_strap_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(strap_test));

    always @(negedge clk) begin
        if (rst) begin
            a_r8_pad_released: assert (cs_oe[0] == 1'b0);
        end
    end

endmodule

bind csel_gen csel_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_addr    (io_addr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .enc_mode   (enc_mode),
    .cs_out     (cs_out),
    .cs_oe      (cs_oe),
    .strap_test (strap_test)
);

// File: tb/csel_gen_tb.sv
module csel_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cs0_pad_in = 1'b1;
    logic [2:0]  cs_out;
    logic [2:0]  cs_oe;
    logic        strap_test;

    int checks = 0;
    int fails  = 0;

    logic [15:0] sb_base [3];
    logic [7:0]  sb_mask [3];
    logic        sb_en   [3];
    logic        sb_enc;

    always #10 clk = ~clk;

    csel_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .io_addr    (io_addr),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cs0_pad_in (cs0_pad_in),
        .cs_out     (cs_out),
        .cs_oe      (cs_oe),
        .strap_test (strap_test)
    );

    task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b (addr %h rd %b wr %b)",
                     req, got, exp, io_addr, io_rd, io_wr);
        end
    endtask

    function automatic logic exp_hit(input int n, input logic [15:0] a);
        logic [15:0] keep;
        keep = ~{8'h00, sb_mask[n]};
        return sb_en[n] && ((a & keep) == (sb_base[n] & keep));
    endfunction

    function automatic logic [2:0] exp_cs(input logic [15:0] a, input logic strobe);
        logic [2:0] h;
        for (int i = 0; i < 3; i++) h[i] = exp_hit(i, a);
        if (!strobe) return 3'b111;
        if (!sb_enc) return ~h;
        if (a >= 16'h03F8 && a <= 16'h03FF) return 3'b000;
        if (a >= 16'h02F8 && a <= 16'h02FF) return 3'b001;
        if (a >= 16'h0378 && a <= 16'h037F) return 3'b010;
        if (a >= 16'h01F0 && a <= 16'h01F7) return 3'b011;
        if (h[0]) return 3'b100;
        if (h[1]) return 3'b101;
        if (h[2]) return 3'b110;
        return 3'b111;
    endfunction

    task automatic clear_shadow();
        for (int i = 0; i < 3; i++) begin
            sb_base[i] = '0; sb_mask[i] = '0; sb_en[i] = 1'b0;
        end
        sb_enc = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1 cfg_we = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (a == 8'(8'h64 + 4*i)) begin sb_base[i][7:0]  = d; sb_en[i] = 1'b1; end
            if (a == 8'(8'h65 + 4*i)) begin sb_base[i][15:8] = d; sb_en[i] = 1'b1; end
            if (a == 8'(8'h66 + 4*i)) begin sb_mask[i]       = d; sb_en[i] = 1'b1; end
        end
        if (a == 8'h4C) sb_enc = d[4];
    endtask

    task automatic probe(input string req, input logic [15:0] a,
                         input logic rd, input logic wr);
        @(negedge clk);
        io_addr = a; io_rd = rd; io_wr = wr;
        #2 chk(req, cs_out, exp_cs(a, rd | wr));
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst = 1'b1; cs0_pad_in = strap; io_rd = 1'b0; io_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 oe during reset", cs_oe, 3'b110);
        rst = 1'b0;
        clear_shadow();
        @(posedge clk);
        #1 cs0_pad_in = ~strap;
        repeat (2) @(negedge clk);
        chk("R9 strap latched", {2'b00, strap_test}, {2'b00, strap});
        chk("R8 oe after reset", cs_oe, 3'b111);
        chk("R7 idle after reset", cs_out, 3'b111);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_shadow();
        do_reset(1'b0);
        do_reset(1'b1);

        // R3: base and mask are zero, but no register is written yet
        probe("R3 disabled window", 16'h0000, 1'b1, 1'b0);

        // R1/R2/R4: window 0 at 0300h with mask 0Fh
        wr_reg(8'h64, 8'h00);
        wr_reg(8'h65, 8'h03);
        wr_reg(8'h66, 8'h0F);
        probe("R4 win0 hit", 16'h030A, 1'b1, 1'b0);
        chk("R4 win0 low", cs_out, 3'b110);
        probe("R2 win0 miss", 16'h0310, 1'b1, 1'b0);
        // R3: writing only the mask enables window 1
        wr_reg(8'h6A, 8'hFF);
        probe("R3 win1 mask only", 16'h0042, 1'b0, 1'b1);
        chk("R3 win1 low", cs_out, 3'b101);
        probe("R7 no strobe", 16'h030A, 1'b0, 1'b0);

        // R5: encoded mode
        wr_reg(8'h4C, 8'h10);
        probe("R5 serial A", 16'h03F9, 1'b1, 1'b0);
        probe("R5 serial B", 16'h02FF, 1'b1, 1'b0);
        probe("R5 parallel", 16'h037A, 1'b0, 1'b1);
        probe("R5 disk", 16'h01F3, 1'b1, 1'b0);
        probe("R5 win0 code", 16'h0305, 1'b1, 1'b0);
        probe("R5 win1 code", 16'h0042, 1'b1, 1'b0);
        probe("R5 none", 16'h8000, 1'b1, 1'b0);
        probe("R7 enc idle", 16'h03F9, 1'b0, 1'b0);

        // R6: window 2 over serial A, then inside window 1
        wr_reg(8'h6C, 8'hF8);
        wr_reg(8'h6D, 8'h03);
        wr_reg(8'h6E, 8'h07);
        probe("R6 fixed beats win2", 16'h03FC, 1'b1, 1'b0);
        chk("R6 code 000", cs_out, 3'b000);
        wr_reg(8'h6C, 8'h30);
        wr_reg(8'h6D, 8'h00);
        wr_reg(8'h6E, 8'h0F);
        probe("R6 win1 beats win2", 16'h0035, 1'b1, 1'b0);
        chk("R6 code 101", cs_out, 3'b101);
        wr_reg(8'h4C, 8'h00);
        probe("R4 overlap both low", 16'h0035, 1'b1, 1'b0);
        chk("R4 two lines low", cs_out, 3'b001);

        // R10: random mix of register writes and accesses
        for (int it = 0; it < 600; it++) begin
            int sel;
            logic [15:0] a;
            sel = int'($urandom % 8);
            if (sel == 0) begin
                int r;
                r = int'($urandom % 10);
                if (r == 9) wr_reg(8'h4C, 8'($urandom));
                else wr_reg(8'(8'h64 + 4*(r/3) + (r%3)), 8'($urandom));
            end else begin
                case ($urandom % 4)
                    0: a = {sb_base[$urandom % 3][15:8], 8'($urandom)};
                    1: a = 16'h01F0 + 16'($urandom % 16'h0210);
                    2: a = 16'($urandom);
                    default: a = 16'h0300 + 16'($urandom % 256);
                endcase
                probe("R10 random", a, 1'($urandom), 1'($urandom));
            end
        end

        // R1: reset clears registers
        wr_reg(8'h6A, 8'hFF);
        probe("R1 before reset", 16'h0035, 1'b1, 1'b0);
        do_reset(1'b0);
        probe("R1 cleared by reset", 16'h0035, 1'b1, 1'b0);
        chk("R1 idle after clear", cs_out, 3'b111);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule